// File: doc/BRIEF.md
# Multi-master lock semaphore bank

This block holds a bank of lock semaphores that several bus masters share to guard common resources. Every bus access carries a 4-bit core ID sideband that names the master making it. A lock records its owner as that core ID plus an 8-bit process ID. A master can take a lock in one of two ways. The first is to write a lock request and then read the register back to confirm that it owns the lock. The second is to read an alias address, which takes a free lock in a single access. Release is protected: a lock is freed only when the writer's core ID and process ID both match the owner's.

A master can also free every lock held by one core in a single write, provided it presents the 16-bit key stored in a programmable key register. Every release, whether single or bulk, sets a status bit for that semaphore. Each core has its own group of enable, status and clear registers and its own interrupt line, so a waiting master can sleep until a lock is freed.

The bus is a simple synchronous word-addressed port. Addresses are word indexes, decimal: semaphore i at i, its lock-on-read alias at 32+i, bulk release at 64, key at 65, and the group for core index c at 80+4c (+0 enable, +1 status, +2 clear).

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore reads zero, the key reads zero, all enable and status bits are zero and both interrupt lines are low.
- R2: A write with data bit 31 set to a free semaphore locks it. The owner core is taken from the core sideband and the process ID from data bits 7:0. A read then returns bit 31 = 1, the core in bits 11:8 and the process ID in bits 7:0.
- R3: A lock write to a semaphore that is already locked is ignored. Its contents stay unchanged, even when the writer is the owner.
- R4: A read of the alias address of a free semaphore locks it for the reading core with process ID 0 and returns the new contents. On a locked semaphore the same read returns the current contents and changes nothing.
- R5: A write with bit 31 clear frees a locked semaphore only if the sideband core equals the owner core and data bits 7:0 equal the owner process ID. A freed semaphore reads zero. Any mismatch leaves it unchanged.
- R6: A write to the bulk-release address whose data bits 31:16 equal the key frees every locked semaphore whose owner core equals data bits 11:8. With a wrong key, nothing changes.
- R7: The key register holds data bits 15:0 on write and returns them in bits 15:0 on read.
- R8: Each release, single or bulk, sets that semaphore's status bit in every core's status register. Writing 1s to a core's clear address clears those bits in that core's status only. Status writes are ignored.
- R9: Interrupt line c is high exactly when some bit is both enabled and set in core group c.
- R10: Read data is valid in the cycle after the read strobe and shows the state after that access. It is zero at unmapped addresses, at the bulk-release and clear addresses, and in cycles without a preceding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_core | input | 4 | Core ID of the accessing master |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 2 | Interrupt per core index |

## Verification
The assertions assume one bus operation per cycle: the read and write strobes are never high together. The bench keeps to this because every access goes through a single task that raises only one strobe for one cycle. The release and lock checks also assume the core sideband holds steady for the whole strobe cycle. The stimulus changes it only at the falling edge, together with the strobe. Random process IDs are drawn from a small range, and core IDs from four valid codes, so that matching and mismatching unlocks and bulk releases both occur often.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int CORE_W     = 4;
    localparam int PROC_W     = 8;
    localparam int DATA_W     = 32;
    localparam int KEY_W      = 16;
    localparam int NCORES     = 2;
    localparam int LOCK_BIT   = 31;
    localparam int SEM_BASE   = 0;
    localparam int ALIAS_BASE = 32;
    localparam int CTRL_ADDR  = 64;
    localparam int KEY_ADDR   = 65;
    localparam int IRQ_BASE   = 80;
    localparam int IRQ_STRIDE = 4;
    localparam int PAD_W      = DATA_W - 1 - CORE_W - PROC_W;

    typedef struct packed {
        logic              locked;
        logic [CORE_W-1:0] core;
        logic [PROC_W-1:0] proc;
    } sem_t;

    function automatic logic [DATA_W-1:0] sem_word(sem_t s);
        return {s.locked, {PAD_W{1'b0}}, s.core, s.proc};
    endfunction
endpackage

// File: rtl/sem_slot.sv
module sem_slot
    import sem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic              wr_lock,
    input  logic [PROC_W-1:0] wr_proc,
    input  logic              rl_sel,
    input  logic [CORE_W-1:0] req_core,
    input  logic              bulk_go,
    input  logic [CORE_W-1:0] bulk_core,
    output sem_t              state_o,
    output logic              released_o
);
    sem_t sem_d, sem_q;
    logic rel_d;

    always_comb begin
        sem_d = sem_q;
        rel_d = 1'b0;
        if (wr_sel) begin
            if (wr_lock) begin
                if (!sem_q.locked) sem_d = '{locked: 1'b1, core: req_core, proc: wr_proc};
            end else if (sem_q.locked && sem_q.core == req_core && sem_q.proc == wr_proc) begin
                sem_d = '0;
                rel_d = 1'b1;
            end
        end else if (rl_sel) begin
            if (!sem_q.locked) sem_d = '{locked: 1'b1, core: req_core, proc: '0};
        end else if (bulk_go && sem_q.locked && sem_q.core == bulk_core) begin
            sem_d = '0;
            rel_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sem_q <= '0;
        else        sem_q <= sem_d;
    end

    assign state_o    = sem_q;
    assign released_o = rel_d;

    assert_held_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wr_lock && sem_q.locked) |=> $stable(sem_q));

    assert_unlock_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !wr_lock && sem_q.locked &&
         (sem_q.core != req_core || sem_q.proc != wr_proc)) |=> $stable(sem_q));

    assert_alias_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_sel && !wr_sel && !sem_q.locked) |=>
        (sem_q.locked && sem_q.core == $past(req_core) && sem_q.proc == '0));
endmodule

// File: rtl/sem_irq_bank.sv
module sem_irq_bank
    import sem_pkg::*;
#(
    parameter int N_SEM = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCORES-1:0]            ier_we,
    input  logic [NCORES-1:0]            icr_we,
    input  logic [N_SEM-1:0]             wbits,
    input  logic [N_SEM-1:0]             released,
    output logic [NCORES-1:0][N_SEM-1:0] ier_o,
    output logic [NCORES-1:0][N_SEM-1:0] isr_o,
    output logic [NCORES-1:0]            irq_o
);
    typedef struct packed {
        logic [NCORES-1:0][N_SEM-1:0] ier;
        logic [NCORES-1:0][N_SEM-1:0] isr;
    } irq_s;

    irq_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCORES; c++) begin
            if (ier_we[c]) st_d.ier[c] = wbits;
            st_d.isr[c] = (st_q.isr[c] & ~(icr_we[c] ? wbits : '0)) | released;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ier_o = st_q.ier;
    assign isr_o = st_q.isr;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        assign irq_o[c] = |(st_q.ier[c] & st_q.isr[c]);

        assert_release_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (|released) |=> ((st_q.isr[c] & $past(released)) == $past(released)));

        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (icr_we[c] && released == '0) |=> ((st_q.isr[c] & $past(wbits)) == '0));
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int N_SEM  = 6,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    input  logic [3:0]        bus_core,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_ADDR);

    typedef struct packed {
        logic [KEY_W-1:0]  key;
        logic              rd_vld;
        logic [ADDR_W-1:0] rd_addr;
    } top_s;

    top_s st_d, st_q;

    logic [N_SEM-1:0]             sem_wr, alias_rd, released, locked_v;
    sem_t                         sem_st [N_SEM];
    logic [NCORES-1:0]            ier_we, icr_we;
    logic [NCORES-1:0][N_SEM-1:0] ier, isr;
    logic                         bulk_go;

    assign bulk_go = bus_wr && bus_addr == A_CTRL && bus_wdata[31:16] == st_q.key;

    for (genvar i = 0; i < N_SEM; i++) begin : g_sem
        assign sem_wr[i]   = bus_wr && bus_addr == ADDR_W'(SEM_BASE + i);
        assign alias_rd[i] = bus_rd && bus_addr == ADDR_W'(ALIAS_BASE + i);
        assign locked_v[i] = sem_st[i].locked;

        sem_slot i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (sem_wr[i]),
            .wr_lock   (bus_wdata[LOCK_BIT]),
            .wr_proc   (bus_wdata[PROC_W-1:0]),
            .rl_sel    (alias_rd[i]),
            .req_core  (bus_core),
            .bulk_go   (bulk_go),
            .bulk_core (bus_wdata[PROC_W+CORE_W-1:PROC_W]),
            .state_o   (sem_st[i]),
            .released_o(released[i])
        );
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_dec
        assign ier_we[c] = bus_wr && bus_addr == ADDR_W'(IRQ_BASE + IRQ_STRIDE * c);
        assign icr_we[c] = bus_wr && bus_addr == ADDR_W'(IRQ_BASE + IRQ_STRIDE * c + 2);
    end

    sem_irq_bank #(.N_SEM(N_SEM)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ier_we  (ier_we),
        .icr_we  (icr_we),
        .wbits   (bus_wdata[N_SEM-1:0]),
        .released(released),
        .ier_o   (ier),
        .isr_o   (isr),
        .irq_o   (irq)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rd_vld = bus_rd;
        if (bus_rd) st_d.rd_addr = bus_addr;
        if (bus_wr && bus_addr == A_KEY) st_d.key = bus_wdata[KEY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (st_q.rd_vld) begin
            for (int i = 0; i < N_SEM; i++) begin
                if (st_q.rd_addr == ADDR_W'(SEM_BASE + i) || st_q.rd_addr == ADDR_W'(ALIAS_BASE + i))
                    bus_rdata = sem_word(sem_st[i]);
            end
            if (st_q.rd_addr == A_KEY) bus_rdata = 32'(st_q.key);
            for (int c = 0; c < NCORES; c++) begin
                if (st_q.rd_addr == ADDR_W'(IRQ_BASE + IRQ_STRIDE * c))     bus_rdata = 32'(ier[c]);
                if (st_q.rd_addr == ADDR_W'(IRQ_BASE + IRQ_STRIDE * c + 1)) bus_rdata = 32'(isr[c]);
            end
        end
    end

    assert_single_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_badkey_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[31:16] != st_q.key) |=> $stable(locked_v));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rd_vld |-> bus_rdata == '0);
endmodule

// File: tb/test_sem_bank.sv
module test_sem_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_core = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic         m_lock [N];
    logic [3:0]   m_core [N];
    logic [7:0]   m_proc [N];
    logic [15:0]  m_key;
    logic [N-1:0] m_ier [2];
    logic [N-1:0] m_isr [2];

    sem_bank #(.N_SEM(N), .ADDR_W(8)) i_sem_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_core(bus_core),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_lock[i] = 0; m_core[i] = 0; m_proc[i] = 0; end
        m_key = 0;
        for (int c = 0; c < 2; c++) begin m_ier[c] = 0; m_isr[c] = 0; end
    endtask

    task automatic model_free(input int i);
        m_lock[i] = 0; m_core[i] = 0; m_proc[i] = 0;
        for (int c = 0; c < 2; c++) m_isr[c][i] = 1'b1;
    endtask

    function automatic logic [31:0] word_of(input int i);
        return {m_lock[i], 19'b0, m_core[i], m_proc[i]};
    endfunction

    function automatic logic [31:0] model_peek(input logic [7:0] a);
        logic [31:0] r = '0;
        for (int i = 0; i < N; i++) if (a == 8'(i) || a == 8'(32 + i)) r = word_of(i);
        if (a == 8'd65) r = {16'b0, m_key};
        for (int c = 0; c < 2; c++) begin
            if (a == 8'(80 + 4*c)) r = 32'(m_ier[c]);
            if (a == 8'(81 + 4*c)) r = 32'(m_isr[c]);
        end
        return r;
    endfunction

    function automatic logic [1:0] model_irq();
        return {|(m_ier[1] & m_isr[1]), |(m_ier[0] & m_isr[0])};
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] core);
        for (int i = 0; i < N; i++) if (a == 8'(i)) begin
            if (d[31]) begin
                if (!m_lock[i]) begin m_lock[i] = 1; m_core[i] = core; m_proc[i] = d[7:0]; end
            end else if (m_lock[i] && m_core[i] == core && m_proc[i] == d[7:0]) model_free(i);
        end
        if (a == 8'd64 && d[31:16] == m_key)
            for (int i = 0; i < N; i++) if (m_lock[i] && m_core[i] == d[11:8]) model_free(i);
        if (a == 8'd65) m_key = d[15:0];
        for (int c = 0; c < 2; c++) begin
            if (a == 8'(80 + 4*c)) m_ier[c] = d[N-1:0];
            if (a == 8'(82 + 4*c)) m_isr[c] = m_isr[c] & ~d[N-1:0];
        end
    endtask

    task automatic model_read(input logic [7:0] a, input logic [3:0] core, output logic [31:0] r);
        for (int i = 0; i < N; i++)
            if (a == 8'(32 + i) && !m_lock[i]) begin m_lock[i] = 1; m_core[i] = core; m_proc[i] = 0; end
        r = model_peek(a);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] core);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_core = core; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d, core);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [3:0] core, input string req);
        logic [31:0] exp;
        @(negedge clk);
        bus_addr = a; bus_core = core; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        model_read(a, core, exp);
        check(req, bus_rdata, exp);
    endtask

    task automatic check_irq(input string req);
        check(req, 32'(irq), 32'(model_irq()));
    endtask

    function automatic logic [3:0] pick_core();
        case ($urandom % 4)
            0: return 4'h1;
            1: return 4'h3;
            2: return 4'h4;
            default: return 4'h8;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_read(8'd0, 4'h3, "R1 sem0");
        check("R1 sem5 literal", model_peek(8'd5), 32'h0);
        do_read(8'd65, 4'h3, "R1 key");
        do_read(8'd81, 4'h3, "R1 status");
        check("R1 irq", 32'(irq), 32'h0);
        // R10 idle cycle reads zero
        @(negedge clk);
        check("R10 idle", bus_rdata, 32'h0);

        // R2 two-step lock
        do_write(8'd0, 32'h8000_0005, 4'h3);
        do_read(8'd0, 4'h3, "R2 readback");
        check("R2 literal", model_peek(8'd0), 32'h8000_0305);
        // R3 held by other / owner
        do_write(8'd0, 32'h8000_0009, 4'h4);
        do_read(8'd0, 4'h4, "R3 other core");
        do_write(8'd0, 32'h8000_0007, 4'h3);
        do_read(8'd0, 4'h3, "R3 owner relock");
        // R5 guarded unlock
        do_write(8'd0, 32'h0000_0006, 4'h3);
        do_read(8'd0, 4'h3, "R5 wrong proc");
        do_write(8'd0, 32'h0000_0005, 4'h4);
        do_read(8'd0, 4'h3, "R5 wrong core");
        do_write(8'd0, 32'h0000_0005, 4'h3);
        do_read(8'd0, 4'h3, "R5 match");
        check("R5 freed literal", model_peek(8'd0), 32'h0);
        // R8 status set in both cores
        do_read(8'd81, 4'h3, "R8 core0 status");
        do_read(8'd85, 4'h3, "R8 core1 status");
        check_irq("R9 disabled");

        // R4 one-step
        do_read(8'd33, 4'h8, "R4 alias free");
        check("R4 literal", model_peek(8'd1), 32'h8000_0800);
        do_read(8'd33, 4'h1, "R4 alias held");
        // R9 enable and release
        do_write(8'd84, 32'h0000_0002, 4'h1);
        do_write(8'd1, 32'h0000_0000, 4'h8);
        check_irq("R9 enabled release");
        check("R9 literal", 32'(irq), 32'h2);
        // R8 clear core1 only
        do_write(8'd86, 32'h0000_0003, 4'h1);
        do_read(8'd85, 4'h1, "R8 cleared");
        do_read(8'd81, 4'h1, "R8 other kept");
        do_write(8'd81, 32'h0000_0000, 4'h1);
        do_read(8'd81, 4'h1, "R8 status write ignored");
        check_irq("R9 after clear");

        // R7 key
        do_write(8'd65, 32'hDEAD_BEEF, 4'h3);
        do_read(8'd65, 4'h3, "R7 key readback");
        // R6 bulk release
        do_write(8'd2, 32'h8000_0011, 4'h4);
        do_write(8'd3, 32'h8000_0012, 4'h4);
        do_write(8'd4, 32'h8000_0013, 4'h1);
        do_write(8'd64, 32'hBEEE_0400, 4'h3);
        do_read(8'd2, 4'h3, "R6 wrong key");
        do_write(8'd64, 32'hBEEF_0400, 4'h3);
        do_read(8'd2, 4'h3, "R6 freed 2");
        do_read(8'd3, 4'h3, "R6 freed 3");
        do_read(8'd4, 4'h3, "R6 other core kept");
        do_read(8'd81, 4'h3, "R6 status bits");
        // R10 unmapped and write-only
        do_read(8'd30, 4'h3, "R10 unmapped");
        do_read(8'd64, 4'h3, "R10 ctrl reads zero");
        do_read(8'd82, 4'h3, "R10 clear reads zero");

        // random phase
        for (int n = 0; n < 600; n++) begin
            int op;
            int s;
            logic [3:0] core;
            logic [7:0] prc;
            op = $urandom % 9;
            s = $urandom % N;
            core = pick_core();
            prc = 8'($urandom % 3);
            case (op)
                0: do_write(8'(s), {1'b1, 23'b0, prc}, core);
                1: begin
                    if ($urandom % 2 == 0 && m_lock[s]) do_write(8'(s), {24'b0, m_proc[s]}, m_core[s]);
                    else do_write(8'(s), {24'b0, prc}, core);
                end
                2: do_read(8'(32 + s), core, "R4 random alias");
                3: do_write(8'd64, {(($urandom % 2) == 0) ? m_key : 16'(m_key + 1), 4'b0, pick_core(), 8'b0}, core);
                4: do_write(8'd65, 32'($urandom), core);
                5: do_write(8'(80 + 4 * ($urandom % 2)), 32'($urandom), core);
                6: do_write(8'(82 + 4 * ($urandom % 2)), 32'($urandom), core);
                7: do_read(8'(81 + 4 * ($urandom % 2)), core, "R8 random status");
                default: do_read(8'd65, core, "R7 random key");
            endcase
            do_read(8'(s), core, "R2 random sem");
            check_irq("R9 random irq");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule